// File: doc/BRIEF.md
# Disk Controller Register File and Interrupt Logic

This block is the host-facing register bank of a controller that serves up to eight disk drives. A host reaches sixteen word slots through a simple register bus: a select, a write flag, a 4-bit slot number and 16-bit data. Reads are combinational from the slot number. The block stores the command, transfer and geometry registers and applies a fixed write mask to each one. It also derives the live status bits from the drive-side inputs and keeps a level interrupt request that follows done, drive attention and the interrupt enable.

A write of the first control word with its GO bit set starts a command. If no error is pending and the selected drive is present, the block raises `cmd_valid` with the function code and the drive number. That request is a valid/ready interface with back-pressure. The function and drive stay stable, and `cmd_valid` stays high, until a cycle in which `cmd_ready` is high. Completions come back on `cmp_valid` with a drive number and an error code. They have no ready signal and are always accepted. A completion ends the busy period, and a nonzero code is logged as an error against that drive.

Top module: `dkc_regfile`

## Requirements
- R1: After reset, slot 0 reads 0x0080 (done only) and slot 4 reads 0x0040 (input-ready only). Every stored register reads zero and `irq` is low.
- R2: Slot map: 0 control 1, 1 word count, 2 bus address, 3 sector/track, 4 control 2, 5 drive status, 6 drive error, 7 attention/offset, 8 cylinder, 9 spare, 10 data buffer, 11 maintenance. Stores are masked as follows: the bus address forces bit 0 to zero, sector/track keeps 0x071F, the cylinder keeps 0x03FF, the offset keeps 0x00BF and maintenance keeps 0x03FF. The word count, spare and data buffer keep all 16 bits. Slots 5, 6, 12, 13, 14 and 15 ignore writes. Slots 12 to 15 read zero.
- R3: Slot 7 returns the per-drive attention in bits 15:8 (drive n at bit 8+n), above the offset byte. A drive's attention is its input OR'ed with the attention stored for it by R10. Slot 5 describes the drive selected by slot 4 bits 2:0: bit 15 is always 1, bit 14 is attention, bit 13 is busy, bit 7 is present and not busy, and bit 0 is present.
- R4: Slot 0 bit 14 (drive interrupt) is 1 whenever any drive has attention.
- R5: Slot 0 bit 15 (error) is 1 when the selected drive has its error input high, or has a nonzero stored error, or slot 4 bit 12 (no-such-drive) is set. Slot 6 returns the stored error of the selected drive.
- R6: Writing slot 0 with bit 0 (GO) set while the error bit is clear and the selected drive is present does four things. It clears done and sets GO. It raises `cmd_valid` with `cmd_fn` equal to written bits 4:1 and `cmd_drive` equal to the selected drive, and `cmd_valid` holds until `cmd_ready` is high. For any function other than 0, it also zeroes maintenance bits 3:0.
- R7: A GO write made while the error bit is set issues no command and leaves done set. GO reads back 0.
- R8: A GO write that targets an absent drive issues no command, sets slot 4 bit 12, and leaves done set.
- R9: While a command is in progress (GO set), every write is ignored except a slot 0 write with bit 15 set.
- R10: A completion sets done and clears GO. A nonzero code is OR'ed into that drive's stored error and sets that drive's stored attention.
- R11: `irq` follows four rules. A slot 0 write with bit 6 (IE) and bit 7 both 1 raises it. A slot 0 write with IE 0 lowers it. While IE is 1, it rises one cycle after done goes from 0 to 1. While IE is 1, it also rises when drive interrupt and done are both 1. A write of IE alone raises nothing.
- R12: A slot 0 write with bit 15 set is a controller clear. It returns slot 0 to 0x0080 and slot 4 to 0x0040, lowers `irq`, drops a pending command, and zeroes the stored drive errors and attention. It pulses `xfer_abort` for one cycle if a data transfer (function 8 or above) was in progress.
- R13: A slot 4 write with bit 5 set returns the whole block to its reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word slot number |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |
| cmd_valid | output | 1 | Command offered to the drive side |
| cmd_ready | input | 1 | Drive side takes the command |
| cmd_fn | output | 4 | Function code of the command |
| cmd_drive | output | 3 | Target drive of the command |
| xfer_abort | output | 1 | One-cycle pulse: transfer cancelled by clear |
| cmp_valid | input | 1 | Command completion |
| cmp_drive | input | 3 | Drive reporting the completion |
| cmp_code | input | 16 | Error code of the completion, 0 = success |
| drv_attn | input | 8 | Per-drive attention |
| drv_err | input | 8 | Per-drive error present |
| drv_busy | input | 8 | Per-drive busy |
| drv_present | input | 8 | Per-drive present |

## Verification
The interrupt path is driven with four patterns that make the same output mean different things. An enable write without done shows whether a bare enable wrongly requests. Enable with done shows whether the forced request fires. Attention rising while done is already set shows that drive interrupt, and not a done edge, fires the request. A completed command shows the done-edge rule alone. Commands run against a ready drive, against a drive holding back `cmd_ready`, against a pending error and against an absent drive. This separates an issued command from one that was blocked or flagged. Both clear paths run, one with a transfer in flight, so that a partial clear can be told apart from a full reset.

// File: rtl/dkc_pkg.sv
package dkc_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned SLOT_W = 4;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_CTL1  = 4'd0,
    SLOT_WCNT  = 4'd1,
    SLOT_BADR  = 4'd2,
    SLOT_SECT  = 4'd3,
    SLOT_CTL2  = 4'd4,
    SLOT_DSTAT = 4'd5,
    SLOT_DERR  = 4'd6,
    SLOT_ATOF  = 4'd7,
    SLOT_CYL   = 4'd8,
    SLOT_SPARE = 4'd9,
    SLOT_DBUF  = 4'd10,
    SLOT_MAINT = 4'd11,
    SLOT_ECA   = 4'd12,
    SLOT_ECB   = 4'd13,
    SLOT_MX2   = 4'd14,
    SLOT_MX3   = 4'd15
  } slot_e;

  // control word 1 bit positions
  localparam int unsigned C1_GO   = 0;
  localparam int unsigned C1_SPR  = 5;
  localparam int unsigned C1_IE   = 6;
  localparam int unsigned C1_DONE = 7;
  localparam int unsigned C1_DT   = 10;
  localparam int unsigned C1_FMT  = 12;
  localparam int unsigned C1_CLR  = 15;

  // control word 2 bit positions
  localparam int unsigned C2_RLS  = 3;
  localparam int unsigned C2_BAI  = 4;
  localparam int unsigned C2_RST  = 5;

  // store masks
  localparam logic [WORD_W-1:0] SECT_MASK = 16'h071F;
  localparam logic [WORD_W-1:0] CYL_MASK  = 16'h03FF;
  localparam logic [7:0]        OFS_MASK  = 8'hBF;
  localparam logic [9:0]        MNT_MASK  = 10'h3FF;

endpackage

// File: rtl/dkc_drive_err.sv
module dkc_drive_err #(
  parameter int DRIVES = 8,
  parameter int SW     = 3,
  parameter int W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       log_en,
  input  logic [SW-1:0]              log_drv,
  input  logic [W-1:0]               log_code,
  output logic [DRIVES-1:0][W-1:0]   err_q,
  output logic [DRIVES-1:0]          att_q
);

  for (genvar i = 0; i < DRIVES; i++) begin : g_drv
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        err_q[i] <= '0;
        att_q[i] <= 1'b0;
      end else if (log_en && (log_drv == SW'(i))) begin
        err_q[i] <= err_q[i] | log_code;
        if (|log_code) att_q[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dkc_status.sv
module dkc_status #(
  parameter int DRIVES = 8,
  parameter int SW     = 3,
  parameter int W      = 16
) (
  input  logic [SW-1:0]              sel,
  input  logic [DRIVES-1:0]          drv_attn,
  input  logic [DRIVES-1:0]          drv_err,
  input  logic [DRIVES-1:0]          drv_busy,
  input  logic [DRIVES-1:0]          drv_present,
  input  logic [DRIVES-1:0][W-1:0]   err_q,
  input  logic [DRIVES-1:0]          att_q,
  input  logic                       ned,
  output logic [DRIVES-1:0]          attn_all,
  output logic                       di,
  output logic                       err_sum,
  output logic [W-1:0]               dstat_word,
  output logic [W-1:0]               derr_word
);

  logic sel_pres, sel_busy;

  always_comb begin
    attn_all   = drv_attn | att_q;
    di         = |attn_all;
    sel_pres   = drv_present[sel];
    sel_busy   = drv_busy[sel];
    derr_word  = err_q[sel];
    err_sum    = drv_err[sel] | (|err_q[sel]) | ned;
    dstat_word = {1'b1, attn_all[sel], sel_busy, 5'b0,
                  sel_pres & ~sel_busy, 6'b0, sel_pres};
  end

endmodule

// File: rtl/dkc_irq.sv
module dkc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ctl_wr,
  input  logic wr_ie,
  input  logic wr_done,
  input  logic ie,
  input  logic done,
  input  logic di,
  output logic irq
);

  logic done_prev_q;
  logic done_rise;

  assign done_rise = done & ~done_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      irq         <= 1'b0;
      done_prev_q <= 1'b1;
    end else begin
      done_prev_q <= done;
      if (ctl_wr) begin
        if (wr_ie) irq <= irq | wr_done;
        else       irq <= 1'b0;
      end else if (ie) begin
        if (done_rise || (di && done)) irq <= 1'b1;
      end else begin
        irq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dkc_regfile.sv
module dkc_regfile
  import dkc_pkg::*;
#(
  parameter int DRIVES = 8,
  parameter int SW     = $clog2(DRIVES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [3:0]        cmd_fn,
  output logic [SW-1:0]     cmd_drive,
  output logic              xfer_abort,
  input  logic              cmp_valid,
  input  logic [SW-1:0]     cmp_drive,
  input  logic [15:0]       cmp_code,
  input  logic [DRIVES-1:0] drv_attn,
  input  logic [DRIVES-1:0] drv_err,
  input  logic [DRIVES-1:0] drv_busy,
  input  logic [DRIVES-1:0] drv_present
);

  localparam int W = WORD_W;

  // control word 1 state
  logic            go_q, done_q, ie_q, spr_q, dt_q, fmt_q;
  logic [3:0]      fn_q;
  logic [1:0]      uae_q;
  // control word 2 state
  logic [SW-1:0]   sel_q;
  logic            rls_q, bai_q, ned_q;
  // plain registers
  logic [W-1:0]    wcnt_q, badr_q, sect_q, cyl_q, spare_q, dbuf_q;
  logic [7:0]      ofs_q;
  logic [9:0]      mnt_q;
  // command port
  logic            pend_q;
  logic [3:0]      cfn_q;
  logic [SW-1:0]   cdrv_q;
  logic            abort_q;

  // status
  logic [DRIVES-1:0]        attn_all, att_q;
  logic [DRIVES-1:0][W-1:0] err_q;
  logic                     di, err_sum;
  logic [W-1:0]             dstat_word, derr_word;

  // access decode
  slot_e slot;
  logic  wr_any, ctl_clr, wr_ok, ctl_wr, blk_rst, go_req, go_start, go_absent;
  logic  cmp_take, clr_evt;

  always_comb begin
    slot      = slot_e'(bus_addr);
    wr_any    = bus_sel && bus_wr;
    ctl_clr   = wr_any && (slot == SLOT_CTL1) && bus_wdata[C1_CLR];
    wr_ok     = wr_any && !go_q && !ctl_clr;
    ctl_wr    = wr_ok && (slot == SLOT_CTL1);
    blk_rst   = wr_ok && (slot == SLOT_CTL2) && bus_wdata[C2_RST];
    go_req    = ctl_wr && bus_wdata[C1_GO] && !err_sum;
    go_start  = go_req && drv_present[sel_q];
    go_absent = go_req && !drv_present[sel_q];
    cmp_take  = cmp_valid && go_q;
    clr_evt   = ctl_clr || blk_rst;
  end

  dkc_drive_err #(.DRIVES(DRIVES), .SW(SW), .W(W)) u_derr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_evt),
    .log_en   (cmp_valid && !clr_evt),
    .log_drv  (cmp_drive),
    .log_code (cmp_code),
    .err_q    (err_q),
    .att_q    (att_q)
  );

  dkc_status #(.DRIVES(DRIVES), .SW(SW), .W(W)) u_stat (
    .sel         (sel_q),
    .drv_attn    (drv_attn),
    .drv_err     (drv_err),
    .drv_busy    (drv_busy),
    .drv_present (drv_present),
    .err_q       (err_q),
    .att_q       (att_q),
    .ned         (ned_q),
    .attn_all    (attn_all),
    .di          (di),
    .err_sum     (err_sum),
    .dstat_word  (dstat_word),
    .derr_word   (derr_word)
  );

  dkc_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_evt),
    .ctl_wr  (ctl_wr),
    .wr_ie   (bus_wdata[C1_IE]),
    .wr_done (bus_wdata[C1_DONE]),
    .ie      (ie_q),
    .done    (done_q),
    .di      (di),
    .irq     (irq)
  );

  // control words and command port
  always_ff @(posedge clk) begin
    if (!rst_n || clr_evt) begin
      go_q   <= 1'b0;
      done_q <= 1'b1;
      ie_q   <= 1'b0;
      spr_q  <= 1'b0;
      dt_q   <= 1'b0;
      fmt_q  <= 1'b0;
      fn_q   <= '0;
      uae_q  <= '0;
      sel_q  <= '0;
      rls_q  <= 1'b0;
      bai_q  <= 1'b0;
      ned_q  <= 1'b0;
      pend_q <= 1'b0;
      cfn_q  <= '0;
      cdrv_q <= '0;
    end else begin
      if (ctl_wr) begin
        fn_q  <= bus_wdata[4:1];
        spr_q <= bus_wdata[C1_SPR];
        ie_q  <= bus_wdata[C1_IE];
        uae_q <= bus_wdata[9:8];
        dt_q  <= bus_wdata[C1_DT];
        fmt_q <= bus_wdata[C1_FMT];
      end
      if (go_start) begin
        go_q   <= 1'b1;
        done_q <= 1'b0;
        pend_q <= 1'b1;
        cfn_q  <= bus_wdata[4:1];
        cdrv_q <= sel_q;
      end else if (cmp_take) begin
        go_q   <= 1'b0;
        done_q <= 1'b1;
        pend_q <= 1'b0;
      end else if (pend_q && cmd_ready) begin
        pend_q <= 1'b0;
      end
      if (go_absent) ned_q <= 1'b1;
      if (wr_ok && (slot == SLOT_CTL2)) begin
        sel_q <= bus_wdata[SW-1:0];
        rls_q <= bus_wdata[C2_RLS];
        bai_q <= bus_wdata[C2_BAI];
      end
    end
  end

  // plain registers; controller clear leaves them alone
  always_ff @(posedge clk) begin
    if (!rst_n || blk_rst) begin
      wcnt_q  <= '0;
      badr_q  <= '0;
      sect_q  <= '0;
      cyl_q   <= '0;
      spare_q <= '0;
      dbuf_q  <= '0;
      ofs_q   <= '0;
      mnt_q   <= '0;
    end else if (wr_ok) begin
      unique case (slot)
        SLOT_WCNT:  wcnt_q  <= bus_wdata;
        SLOT_BADR:  badr_q  <= {bus_wdata[W-1:1], 1'b0};
        SLOT_SECT:  sect_q  <= bus_wdata & SECT_MASK;
        SLOT_CYL:   cyl_q   <= bus_wdata & CYL_MASK;
        SLOT_SPARE: spare_q <= bus_wdata;
        SLOT_DBUF:  dbuf_q  <= bus_wdata;
        SLOT_ATOF:  ofs_q   <= bus_wdata[7:0] & OFS_MASK;
        SLOT_MAINT: mnt_q   <= bus_wdata[9:0] & MNT_MASK;
        SLOT_CTL1:  if (go_start && (bus_wdata[4:1] != 4'd0)) mnt_q[3:0] <= 4'd0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= ctl_clr && go_q && fn_q[3];
  end

  // read mux
  always_comb begin
    unique case (slot)
      SLOT_CTL1:  bus_rdata = {err_sum, di, 1'b0, fmt_q, 1'b0, dt_q, uae_q,
                               done_q, ie_q, spr_q, fn_q, go_q};
      SLOT_WCNT:  bus_rdata = wcnt_q;
      SLOT_BADR:  bus_rdata = badr_q;
      SLOT_SECT:  bus_rdata = sect_q;
      SLOT_CTL2:  bus_rdata = {3'b0, ned_q, 4'b0, 1'b0, 1'b1, 1'b0,
                               bai_q, rls_q, 3'(sel_q)};
      SLOT_DSTAT: bus_rdata = dstat_word;
      SLOT_DERR:  bus_rdata = derr_word;
      SLOT_ATOF:  bus_rdata = {8'(attn_all), ofs_q};
      SLOT_CYL:   bus_rdata = cyl_q;
      SLOT_SPARE: bus_rdata = spare_q;
      SLOT_DBUF:  bus_rdata = dbuf_q;
      SLOT_MAINT: bus_rdata = {6'b0, mnt_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign cmd_valid  = pend_q;
  assign cmd_fn     = cfn_q;
  assign cmd_drive  = cdrv_q;
  assign xfer_abort = abort_q;

endmodule

// File: rtl/dkc_regfile_chk.sv
module dkc_regfile_chk #(
  parameter int DRIVES = 8,
  parameter int SW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              ie,
  input logic              go,
  input logic              done,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_fn,
  input logic [SW-1:0]     cmd_drive,
  input logic              clr_evt,
  input logic              ctl_clr,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [3:0]        bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       badr,
  input logic [DRIVES-1:0] drv_attn,
  input logic              di
);

  assert_irq_needs_ie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);

  assert_go_excl_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && done));

  assert_cmd_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !done);

  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !clr_evt) |=>
      (cmd_valid && $stable(cmd_fn) && $stable(cmd_drive)));

  assert_badr_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 4'd2 && !go) |=>
      (badr == {$past(bus_wdata[15:1]), 1'b0}));

  assert_attn_di_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|drv_attn) |-> di);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr |=> (done && !go && !irq && !cmd_valid && !ie));

endmodule

bind dkc_regfile dkc_regfile_chk #(.DRIVES(DRIVES), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .ie        (ie_q),
  .go        (go_q),
  .done      (done_q),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_fn    (cmd_fn),
  .cmd_drive (cmd_drive),
  .clr_evt   (clr_evt),
  .ctl_clr   (ctl_clr),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .badr      (badr_q),
  .drv_attn  (drv_attn),
  .di        (di)
);

// File: tb/dkc_regfile_tb.sv
module dkc_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, cmd_valid, xfer_abort;
  logic        cmd_ready = 1'b0;
  logic [3:0]  cmd_fn;
  logic [2:0]  cmd_drive;
  logic        cmp_valid = 1'b0;
  logic [2:0]  cmp_drive = '0;
  logic [15:0] cmp_code = '0;
  logic [7:0]  drv_attn = '0, drv_err = '0, drv_busy = '0, drv_present = 8'hFF;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  dkc_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_fn(cmd_fn), .cmd_drive(cmd_drive), .xfer_abort(xfer_abort),
    .cmp_valid(cmp_valid), .cmp_drive(cmp_drive), .cmp_code(cmp_code),
    .drv_attn(drv_attn), .drv_err(drv_err), .drv_busy(drv_busy),
    .drv_present(drv_present)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data against queued expectations
  always @(negedge clk) begin
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard underflow actual=%h expected=none", bus_rdata);
      end else begin
        logic [15:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk) #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk) #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(posedge clk) #1;
    exp_q.push_back(e); tag_q.push_back(t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk) #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic complete(input logic [2:0] d, input logic [15:0] c);
    @(posedge clk) #1;
    cmp_valid = 1'b1; cmp_drive = d; cmp_code = c;
    @(posedge clk) #1;
    cmp_valid = 1'b0; cmp_code = '0;
  endtask

  task automatic accept();
    @(posedge clk) #1; cmd_ready = 1'b1;
    @(posedge clk) #1; cmd_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(4'd0, 16'h0080, "R1 ctl1 reset");
    rd(4'd4, 16'h0040, "R1 ctl2 reset");
    rd(4'd1, 16'h0000, "R1 wcnt reset");
    @(negedge clk); check("R1 irq reset", {15'd0, irq}, 16'd0);

    // R2 masks and read-only slots
    wr(4'd1, 16'h1234); rd(4'd1, 16'h1234, "R2 wcnt");
    wr(4'd2, 16'hFFFF); rd(4'd2, 16'hFFFE, "R2 badr lsb");
    wr(4'd3, 16'hFFFF); rd(4'd3, 16'h071F, "R2 sect mask");
    wr(4'd8, 16'hFFFF); rd(4'd8, 16'h03FF, "R2 cyl mask");
    wr(4'd7, 16'h00FF); rd(4'd7, 16'h00BF, "R2 offset mask");
    wr(4'd11, 16'hFFFF); rd(4'd11, 16'h03FF, "R2 maint mask");
    wr(4'd10, 16'hA5C3); rd(4'd10, 16'hA5C3, "R2 dbuf");
    wr(4'd6, 16'hFFFF); rd(4'd6, 16'h0000, "R2 derr ignores write");
    wr(4'd14, 16'hFFFF); rd(4'd14, 16'h0000, "R2 mx2 reads zero");
    rd(4'd12, 16'h0000, "R2 eca reads zero");

    // R3 / R4 attention, drive status
    drv_attn = 8'h05;
    rd(4'd7, 16'h05BF, "R3 attention byte");
    rd(4'd5, 16'hC081, "R3 drive status");
    rd(4'd0, 16'h4080, "R4 drive interrupt");
    drv_attn = 8'h00;
    // R5 error from selected drive input
    drv_err = 8'h01;
    rd(4'd0, 16'h8080, "R5 error bit");
    drv_err = 8'h00;

    // R11 irq forms
    wr(4'd0, 16'h0040);
    idle(2); @(negedge clk); check("R11 ie alone no irq", {15'd0, irq}, 16'd0);
    wr(4'd0, 16'h00C0);
    @(negedge clk); check("R11 ie+done forces irq", {15'd0, irq}, 16'd1);
    wr(4'd0, 16'h0000);
    @(negedge clk); check("R11 ie clear drops irq", {15'd0, irq}, 16'd0);
    wr(4'd0, 16'h0040);
    drv_attn = 8'h08;
    idle(2); @(negedge clk); check("R11 di with done raises irq", {15'd0, irq}, 16'd1);
    drv_attn = 8'h00;
    wr(4'd0, 16'h0000);

    // R6 command with back-pressure, R9 busy writes, R10 completion
    wr(4'd4, 16'h0003);
    rd(4'd4, 16'h0043, "R2 ctl2 select");
    wr(4'd0, 16'h0051);
    @(negedge clk); check("R6 cmd_valid", {15'd0, cmd_valid}, 16'd1);
    check("R6 cmd_fn", {12'd0, cmd_fn}, 16'd8);
    check("R6 cmd_drive", {13'd0, cmd_drive}, 16'd3);
    idle(3); @(negedge clk); check("R6 cmd held under back-pressure", {15'd0, cmd_valid}, 16'd1);
    wr(4'd1, 16'h0000);
    rd(4'd1, 16'h1234, "R9 busy write ignored");
    rd(4'd0, 16'h0051, "R6 ctl1 busy");
    rd(4'd11, 16'h03F0, "R6 maint select cleared");
    accept();
    @(negedge clk); check("R6 cmd taken", {15'd0, cmd_valid}, 16'd0);
    complete(3'd3, 16'h0000);
    idle(1); @(negedge clk); check("R11 done rise raises irq", {15'd0, irq}, 16'd1);
    rd(4'd0, 16'h00D0, "R10 done set go clear");

    // R10 rejected command
    wr(4'd0, 16'h0000);
    wr(4'd0, 16'h000F);
    accept();
    complete(3'd3, 16'h0020);
    rd(4'd6, 16'h0020, "R10 error logged");
    rd(4'd0, 16'hC08E, "R10 err di done");
    rd(4'd7, 16'h08BF, "R10 attention stored");

    // R7 GO blocked by error
    wr(4'd0, 16'h0001);
    @(negedge clk); check("R7 no command", {15'd0, cmd_valid}, 16'd0);
    rd(4'd0, 16'hC080, "R7 go reads zero");

    // R12 controller clear
    wr(4'd0, 16'h8000);
    rd(4'd0, 16'h0080, "R12 ctl1 after clear");
    rd(4'd4, 16'h0040, "R12 ctl2 after clear");
    wr(4'd4, 16'h0003);
    rd(4'd6, 16'h0000, "R12 drive error cleared");
    rd(4'd7, 16'h00BF, "R12 attention cleared");

    // R8 absent drive
    drv_present = 8'hDF;
    wr(4'd4, 16'h0005);
    wr(4'd0, 16'h0009);
    @(negedge clk); check("R8 no command", {15'd0, cmd_valid}, 16'd0);
    rd(4'd4, 16'h1045, "R8 no-drive flag");
    rd(4'd0, 16'h8088, "R8 error and done");
    drv_present = 8'hFF;

    // R13 full reset
    wr(4'd4, 16'h0020);
    rd(4'd4, 16'h0040, "R13 ctl2");
    rd(4'd0, 16'h0080, "R13 ctl1");
    rd(4'd1, 16'h0000, "R13 wcnt");
    rd(4'd11, 16'h0000, "R13 maint");
    rd(4'd7, 16'h0000, "R13 offset");

    // R12 abort of a transfer in flight
    wr(4'd0, 16'h0011);
    @(negedge clk); check("R12 read issued", {15'd0, cmd_valid}, 16'd1);
    wr(4'd0, 16'h8000);
    @(negedge clk); check("R12 xfer_abort pulse", {15'd0, xfer_abort}, 16'd1);
    check("R12 pending dropped", {15'd0, cmd_valid}, 16'd0);
    idle(1); @(negedge clk); check("R12 abort one cycle", {15'd0, xfer_abort}, 16'd0);
    rd(4'd0, 16'h0080, "R12 ctl1 after abort");

    idle(2);
    finish_run();
  end

endmodule